// File: doc/BRIEF.md
# Per-Flow Cell Load Balancer

This block is the dispatch stage of an ingress switching element in a three-stage Clos packet switch. Each arriving cell carries a source port and a destination port. From these two fields the block forms a flow key. The key indexes a table of small rotating counters, one counter per flow. The current value of that flow's counter names the center-stage element that the cell goes through. The block emits an enqueue strobe together with the index of the virtual output queue (VOQ) that feeds that center element. The same cell then advances the flow's counter, wrapping modulo the number of center elements. As a result, every flow is spread evenly over the middle stage, in strict rotation.

A static two-bit mode input sets how coarse a flow is. The source side of the key can be the individual port or the edge element that holds it. The destination side can be the individual port or the egress edge element it belongs to. An edge element index is a port number divided by the number of ports per edge element. The mode is expected to change only while reset is held.

Top module: `lb_dispatch`

## Requirements
- R1: While reset is high at a clock edge, the enqueue strobe is low after that edge and every flow counter returns to zero. The first cell of any flow after reset therefore selects center 0.
- R2: A cell presented with the valid strobe high at a rising edge produces exactly one enqueue pulse in the following cycle. The VOQ index in that cycle equals the flow's counter value before the cell.
- R3: Each dispatched cell advances its own flow's counter by one, modulo the number of center elements, so the value after CENTERS-1 is 0. No other flow's counter changes.
- R4: For any flow, k*CENTERS consecutive cells of that flow place exactly k cells on each center element, in the order 0,1,...,CENTERS-1,0,...
- R5: Mode 0 keys a flow by (source port, destination port), so two destination ports always have separate counters.
- R6: Mode 1 keys a flow by (source port, destination port / EDGE_PORTS), so destinations on the same egress edge element share a counter.
- R7: Mode 2 keys a flow by (source port / EDGE_PORTS, destination port), so sources on the same ingress edge element share a counter.
- R8: Mode 3 keys a flow by (source port / EDGE_PORTS, destination port / EDGE_PORTS).
- R9: Cells of one flow on consecutive clock cycles receive consecutive center indices. The second cell sees the update made by the first.
- R10: A cycle with the valid strobe low gives no enqueue pulse in the next cycle and leaves every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Flow granularity select (0 to 3, see R5 to R8), static |
| cell_vld_i | input | 1 | A cell is present this cycle |
| src_port_i | input | PORT_W (4) | Source switch port of the cell |
| dst_port_i | input | PORT_W (4) | Destination switch port of the cell |
| enq_o | output | 1 | Enqueue strobe, one cycle after the cell |
| voq_sel_o | output | CTR_W (2) | VOQ / center element chosen for the cell |

## Verification
The counter read for a new cell and the counter write-back of the previous cell can fall in the same cycle. This happens when cells of one flow arrive on consecutive cycles. It also happens in the coarse modes, when cells from different ports that fold into one key arrive back to back. The bench provokes both cases with uninterrupted streams of cells. It judges them against its own per-key counter model, which requires the second cell to see the first cell's increment, and it also checks the per-center histogram of the stream.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [1:0] {
        KEY_PORT_PORT = 2'd0,
        KEY_PORT_SE   = 2'd1,
        KEY_SE_PORT   = 2'd2,
        KEY_SE_SE     = 2'd3
    } key_mode_e;

    // Next center index, wrapping at the number of center elements.
    function automatic int wrap_inc(input int cur, input int lim);
        return (cur >= lim - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/lb_flow_key.sv
module lb_flow_key
    import lb_pkg::*;
#(
    parameter int N_PORTS    = 16,
    parameter int EDGE_PORTS = 4,
    parameter int PORT_W     = $clog2(N_PORTS),
    parameter int KEY_W      = 2 * PORT_W
) (
    input  key_mode_e         mode_i,
    input  logic [PORT_W-1:0] src_i,
    input  logic [PORT_W-1:0] dst_i,
    output logic [KEY_W-1:0]  key_o
);

    logic [PORT_W-1:0] src_part;
    logic [PORT_W-1:0] dst_part;

    always_comb begin
        src_part = src_i;
        dst_part = dst_i;
        if (mode_i == KEY_SE_PORT || mode_i == KEY_SE_SE) begin
            src_part = PORT_W'(int'(src_i) / EDGE_PORTS);
        end
        if (mode_i == KEY_PORT_SE || mode_i == KEY_SE_SE) begin
            dst_part = PORT_W'(int'(dst_i) / EDGE_PORTS);
        end
        key_o = {src_part, dst_part};
    end

endmodule

// File: rtl/lb_ctr_table.sv
module lb_ctr_table
    import lb_pkg::*;
#(
    parameter int KEY_W   = 8,
    parameter int CENTERS = 4,
    parameter int CTR_W   = (CENTERS > 1) ? $clog2(CENTERS) : 1,
    parameter int DEPTH   = 1 << KEY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] idx_i,
    input  logic             bump_i,
    output logic [CTR_W-1:0] cur_o
);

    logic [CTR_W-1:0] tbl_d [DEPTH];
    logic [CTR_W-1:0] tbl_q [DEPTH];

    // Read and advance in one cycle; a cell on the next cycle reads the new value.
    assign cur_o = tbl_q[idx_i];

    always_comb begin
        tbl_d = tbl_q;
        if (bump_i) begin
            tbl_d[idx_i] = CTR_W'(wrap_inc(int'(tbl_q[idx_i]), CENTERS));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '{default: '0};
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/lb_dispatch.sv
module lb_dispatch
    import lb_pkg::*;
#(
    parameter int N_PORTS    = 16,
    parameter int EDGE_PORTS = 4,
    parameter int CENTERS    = 4,
    parameter int PORT_W     = $clog2(N_PORTS),
    parameter int CTR_W      = (CENTERS > 1) ? $clog2(CENTERS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              cell_vld_i,
    input  logic [PORT_W-1:0] src_port_i,
    input  logic [PORT_W-1:0] dst_port_i,
    output logic              enq_o,
    output logic [CTR_W-1:0]  voq_sel_o
);

    localparam int KEY_W = 2 * PORT_W;

    typedef struct packed {
        logic             enq;
        logic [CTR_W-1:0] voq;
    } disp_t;

    disp_t            disp_d, disp_q;
    logic [KEY_W-1:0] flow_key;
    logic [CTR_W-1:0] flow_ctr;

    lb_flow_key #(
        .N_PORTS    (N_PORTS),
        .EDGE_PORTS (EDGE_PORTS),
        .PORT_W     (PORT_W),
        .KEY_W      (KEY_W)
    ) u_key (
        .mode_i (key_mode_e'(mode_i)),
        .src_i  (src_port_i),
        .dst_i  (dst_port_i),
        .key_o  (flow_key)
    );

    lb_ctr_table #(
        .KEY_W   (KEY_W),
        .CENTERS (CENTERS),
        .CTR_W   (CTR_W)
    ) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .idx_i  (flow_key),
        .bump_i (cell_vld_i),
        .cur_o  (flow_ctr)
    );

    always_comb begin
        disp_d.enq = cell_vld_i;
        disp_d.voq = cell_vld_i ? flow_ctr : disp_q.voq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q <= '0;
        end else begin
            disp_q <= disp_d;
        end
    end

    assign enq_o     = disp_q.enq;
    assign voq_sel_o = disp_q.voq;

endmodule

// File: rtl/lb_dispatch_chk.sv
module lb_dispatch_chk #(
    parameter int N_PORTS = 16,
    parameter int CENTERS = 4,
    parameter int PORT_W  = $clog2(N_PORTS),
    parameter int CTR_W   = (CENTERS > 1) ? $clog2(CENTERS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cell_vld_i,
    input logic [PORT_W-1:0] src_port_i,
    input logic [PORT_W-1:0] dst_port_i,
    input logic              enq_o,
    input logic [CTR_W-1:0]  voq_sel_o
);

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !enq_o);

    p_enq_follows_r2: assert property (@(posedge clk) disable iff (rst)
        cell_vld_i |=> enq_o);

    p_idle_no_enq_r10: assert property (@(posedge clk) disable iff (rst)
        !cell_vld_i |=> !enq_o);

    // R9: identical cell fields on consecutive cycles step the center index.
    p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
        (cell_vld_i && $past(cell_vld_i) && !$past(rst)
         && src_port_i == $past(src_port_i) && dst_port_i == $past(dst_port_i))
        |=> (voq_sel_o == (($past(voq_sel_o) == CTR_W'(CENTERS - 1))
                           ? '0 : $past(voq_sel_o) + 1'b1)));

endmodule

bind lb_dispatch lb_dispatch_chk #(
    .N_PORTS (N_PORTS),
    .CENTERS (CENTERS),
    .PORT_W  (PORT_W),
    .CTR_W   (CTR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cell_vld_i (cell_vld_i),
    .src_port_i (src_port_i),
    .dst_port_i (dst_port_i),
    .enq_o      (enq_o),
    .voq_sel_o  (voq_sel_o)
);

// File: tb/tb_lb_dispatch.sv
module tb_lb_dispatch;

    localparam int NP = 16;
    localparam int EP = 4;
    localparam int MC = 4;
    localparam int PW = 4;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          vld = 1'b0;
    logic [PW-1:0] src = '0;
    logic [PW-1:0] dst = '0;
    logic          enq;
    logic [CW-1:0] voq;

    int checks = 0;
    int fails  = 0;
    int model [NP*NP];
    int hist  [MC];
    bit done = 0;

    always #5 clk = ~clk;

    lb_dispatch #(.N_PORTS(NP), .EDGE_PORTS(EP), .CENTERS(MC)) dut (
        .clk(clk), .rst(rst), .mode_i(mode), .cell_vld_i(vld),
        .src_port_i(src), .dst_port_i(dst), .enq_o(enq), .voq_sel_o(voq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int key_of(input int s, input int d);
        int ks = mode[1] ? s / EP : s;
        int kd = mode[0] ? d / EP : d;
        return ks * NP + kd;
    endfunction

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        vld = 1'b0; rst = 1'b1; mode = m;
        foreach (model[i]) model[i] = 0;
        repeat (2) @(negedge clk);
        check("R1 enq low in reset", int'(enq), 0);
        rst = 1'b0;
    endtask

    // Drive one cell at the current negedge, check its dispatch one cycle later.
    task automatic send(input string tag, input int s, input int d);
        int k = key_of(s, d);
        int exp = model[k];
        model[k] = (exp + 1) % MC;
        vld = 1'b1; src = PW'(s); dst = PW'(d);
        @(negedge clk);
        vld = 1'b0;
        check({tag, " R2 enq"}, int'(enq), 1);
        check({tag, " voq"}, int'(voq), exp);
        hist[int'(voq)]++;
    endtask

    task automatic t_reset_first;
        do_reset(2'd0);
        @(negedge clk);
        check("R1 idle after reset", int'(enq), 0);
        send("R1 first cell", 9, 3);
        check("R1 first center zero", int'(voq), 0);
    endtask

    task automatic t_rotation;
        do_reset(2'd0);
        foreach (hist[i]) hist[i] = 0;
        for (int i = 0; i < 3 * MC; i++) send("R4 R9 R3 stream", 2, 5);
        foreach (hist[i]) check("R4 per-center count", hist[i], 3);
    endtask

    task automatic t_idle;
        do_reset(2'd0);
        send("R10 pre", 7, 7);
        repeat (3) begin
            @(negedge clk);
            check("R10 no enq when idle", int'(enq), 0);
        end
        send("R10 resume", 7, 7);
        check("R10 counter kept", int'(voq), 1);
    endtask

    task automatic t_mode0;
        do_reset(2'd0);
        send("R5 a", 1, 4); send("R5 b", 1, 5);
        check("R5 separate dst", int'(voq), 0);
        send("R5 a2", 1, 4); send("R3 other unchanged", 1, 5);
        check("R3 other flow", int'(voq), 1);
    endtask

    task automatic t_mode1;
        do_reset(2'd1);
        send("R6 a", 1, 4); send("R6 b", 1, 5); send("R6 c", 1, 6);
        check("R6 shared out SE", int'(voq), 2);
        send("R6 d", 1, 8);
        check("R6 other out SE", int'(voq), 0);
        send("R6 e", 2, 4);
        check("R6 other src", int'(voq), 0);
    endtask

    task automatic t_mode2;
        do_reset(2'd2);
        send("R7 a", 0, 3); send("R7 b", 1, 3); send("R7 c", 2, 3);
        check("R7 shared in SE", int'(voq), 2);
        send("R7 d", 3, 3); send("R7 wrap", 0, 3);
        check("R3 wrap to zero", int'(voq), 0);
        send("R7 e", 4, 3);
        check("R7 other in SE", int'(voq), 0);
    endtask

    task automatic t_mode3;
        do_reset(2'd3);
        send("R8 a", 0, 0); send("R8 b", 3, 3); send("R8 c", 1, 2);
        check("R8 SE pair shared", int'(voq), 2);
        send("R8 d", 4, 0);
        check("R8 other SE pair", int'(voq), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset_first();
        t_rotation();
        t_idle();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule